// File: doc/BRIEF.md
# Shared-Line Packet Receiver

This block listens to a shared, open-collector serial line and rebuilds the packets that other nodes place on it. Bytes are sent in asynchronous serial form at a fixed bit rate. Each byte has a low start bit, eight data bits sent LSB first, and a high stop bit. Within a packet, bytes follow one another separated only by their stop bits. A packet ends when the line stays high for longer than any all-ones byte could hold it. The block is driven by a sample strobe that pulses four times per bit period, which at the nominal 1200 baud is one strobe every 208 µs. The input line passes through a two-stage synchronizer.

The first byte of a packet names the sender. The low nibble of the second byte gives the number of data bytes that follow, from 0 to 15. When that nibble is zero, the upper nibble carries a small payload of its own. The full count byte is therefore presented on its own output. The data bytes are streamed out one at a time with a one-cycle valid strobe. A checksum byte follows the data. The XOR of every byte from the sender byte through the checksum must be zero. When the idle gap arrives, the block reports the packet as complete and states whether the checksum was good. Malformed packets raise a framing-error pulse instead, and no completion is reported for them.

Top module: `pkt_receiver`

## Requirements
- R1: After reset, all strobes and byte outputs are 0. Bytes on the line are ignored until the line has been high for at least IDLE_BITS bit times (10 × 4 = 40 sample strobes).
- R2: A byte begins when the line is seen low on a strobe. That low level must still be present two strobes later, or the edge is discarded. Data bits are then sampled every four strobes, LSB first, followed by the stop bit.
- R3: The first byte after an idle gap appears on `senderId` and holds until the next packet's first byte.
- R4: The second byte appears in full on `countOut`. Its bits [3:0] give the number of data bytes, from 0 to 15. When that number is zero, no data byte is expected, and bits [7:4] are available on `countOut`.
- R5: Each data byte is presented on `dataOut`, in arrival order, with `dataValid` high for exactly one clock.
- R6: A high level of at least 40 strobes ends a packet. A packet whose data bytes are all 0xFF is not cut short by them.
- R7: When the idle gap follows the checksum byte, `pktDone` pulses for one clock. `csumErr` is high in that same clock exactly when the XOR of all received bytes is non-zero, and it is never high at any other time.
- R8: A byte whose stop bit is sampled low raises `frameErr` for one clock. No `pktDone` follows, and all bytes up to the next idle gap are ignored.
- R9: An idle gap that arrives before the checksum byte raises `frameErr` and produces no `pktDone`.
- R10: A byte received after the checksum and before the idle gap raises `frameErr` and produces no `pktDone`.
- R11: After a completed or failed packet, the next packet that follows an idle gap is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | One-clock strobe, four per bit period |
| rxLine | input | 1 | Shared serial line, asynchronous, idle high |
| senderId | output | 8 | First byte of the current packet |
| countOut | output | 8 | Second byte of the current packet |
| dataOut | output | 8 | Most recent data byte |
| dataValid | output | 1 | One-clock strobe for `dataOut` |
| pktDone | output | 1 | One-clock strobe at the end of a well-formed packet |
| csumErr | output | 1 | Checksum mismatch, valid with `pktDone` |
| frameErr | output | 1 | One-clock strobe for a malformed packet |

## Verification
The assertions assume three things about the inputs. First, `sampleTick` arrives no more often than once every few clocks. Second, the line keeps each level for whole bit periods, so successive accepted bytes lie tens of strobes apart. Third, an idle gap can only be declared while no byte is being shifted in. The stimulus moves the line only at strobe boundaries and leaves at least three clocks between a level change and the next strobe. Every byte it sends is exactly four strobes per bit. The only exceptions are a deliberate one-strobe glitch and a deliberately low stop bit, both used to exercise R2 and R8.

// File: rtl/pkr_pkg.sv
package pkr_pkg;

  // Events raised by the datapath towards the packet sequencer
  typedef struct packed {
    logic byteDone;   // a full byte has been shifted in
    logic stopOk;     // its stop bit was high
    logic idle;       // long-high gap detected
    logic sumZero;    // running XOR is zero
  } evt_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchId;
    logic latchCnt;
    logic emitData;
    logic accSum;
    logic finish;
    logic frameBad;
  } ctrl_t;

  typedef enum logic [1:0] {B_HUNT, B_START, B_BITS} bitState_e;

  typedef enum logic [2:0] {
    S_SYNC, S_ID, S_CNT, S_DATA, S_SUM, S_TAIL, S_DROP
  } pktState_e;

endpackage

// File: rtl/pkr_datapath.sv
module pkr_datapath
  import pkr_pkg::*;
#(
  parameter int OVERSAMPLE = 4,
  parameter int DATA_BITS  = 8,
  parameter int IDLE_BITS  = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleTick,
  input  logic                 rxLine,
  input  ctrl_t                ctl,
  output evt_t                 ev,
  output logic [DATA_BITS-1:0] rxByte,
  output logic [DATA_BITS-1:0] senderId,
  output logic [DATA_BITS-1:0] countOut,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 dataValid,
  output logic                 pktDone,
  output logic                 csumErr,
  output logic                 frameErr
);

  localparam int TICK_W     = $clog2(OVERSAMPLE);
  localparam int BITC_W     = $clog2(DATA_BITS + 1);
  localparam int IDLE_TICKS = IDLE_BITS * OVERSAMPLE;
  localparam int IDLE_W     = $clog2(IDLE_TICKS + 1);
  localparam logic [TICK_W-1:0] CONFIRM_AT = TICK_W'(OVERSAMPLE / 2 - 1);
  localparam logic [TICK_W-1:0] BIT_END    = TICK_W'(OVERSAMPLE - 1);
  localparam logic [BITC_W-1:0] STOP_IDX   = BITC_W'(DATA_BITS);
  localparam logic [IDLE_W-1:0] IDLE_LAST  = IDLE_W'(IDLE_TICKS - 1);
  localparam logic [IDLE_W-1:0] IDLE_FULL  = IDLE_W'(IDLE_TICKS);

  logic [1:0]           syncQ;
  logic                 rxS;
  bitState_e            bState;
  logic [TICK_W-1:0]    tickCnt;
  logic [BITC_W-1:0]    bitCnt;
  logic [IDLE_W-1:0]    idleCnt;
  logic                 byteDoneQ, stopOkQ, idleQ;
  logic [DATA_BITS-1:0] sumAcc;

  assign rxS = syncQ[1];

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[0], rxLine};
  end

  // Bit-level deserializer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bState    <= B_HUNT;
      tickCnt   <= '0;
      bitCnt    <= '0;
      rxByte    <= '0;
      byteDoneQ <= 1'b0;
      stopOkQ   <= 1'b0;
    end else begin
      byteDoneQ <= 1'b0;
      if (sampleTick) begin
        unique case (bState)
          B_HUNT: if (!rxS) begin
            bState  <= B_START;
            tickCnt <= '0;
          end
          B_START: begin
            if (tickCnt == CONFIRM_AT) begin
              tickCnt <= '0;
              bitCnt  <= '0;
              bState  <= rxS ? B_HUNT : B_BITS;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          B_BITS: begin
            if (tickCnt == BIT_END) begin
              tickCnt <= '0;
              if (bitCnt == STOP_IDX) begin
                byteDoneQ <= 1'b1;
                stopOkQ   <= rxS;
                bState    <= B_HUNT;
              end else begin
                rxByte <= {rxS, rxByte[DATA_BITS-1:1]};
                bitCnt <= bitCnt + 1'b1;
              end
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          default: bState <= B_HUNT;
        endcase
      end
    end
  end

  // Long-high gap detector
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
      idleQ   <= 1'b0;
    end else begin
      idleQ <= 1'b0;
      if (sampleTick) begin
        if (!rxS) begin
          idleCnt <= '0;
        end else if (idleCnt != IDLE_FULL) begin
          idleCnt <= idleCnt + 1'b1;
          if (idleCnt == IDLE_LAST) idleQ <= 1'b1;
        end
      end
    end
  end

  assign ev = '{byteDone: byteDoneQ, stopOk: stopOkQ, idle: idleQ,
                sumZero: (sumAcc == '0)};

  // Byte registers, checksum and output strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumAcc    <= '0;
      senderId  <= '0;
      countOut  <= '0;
      dataOut   <= '0;
      dataValid <= 1'b0;
      pktDone   <= 1'b0;
      csumErr   <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      if (ctl.latchId) begin
        senderId <= rxByte;
        sumAcc   <= rxByte;
      end
      if (ctl.latchCnt) countOut <= rxByte;
      if (ctl.emitData) dataOut  <= rxByte;
      if (ctl.latchCnt || ctl.emitData || ctl.accSum) sumAcc <= sumAcc ^ rxByte;
      dataValid <= ctl.emitData;
      pktDone   <= ctl.finish;
      csumErr   <= ctl.finish && (sumAcc != '0);
      frameErr  <= ctl.frameBad;
    end
  end

  AST_START_CONFIRMED: assert property (@(posedge clk) disable iff (!rstN)
    (bState == B_BITS && $past(bState) == B_START) |-> $past(!rxS)); // R2
  AST_IDLE_OUTSIDE_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    idleQ |-> bState == B_HUNT); // R6
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid); // R5
  AST_CSUM_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    csumErr |-> pktDone); // R7
  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(pktDone && frameErr)); // R8

endmodule

// File: rtl/pkr_control.sv
module pkr_control
  import pkr_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int LEN_BITS  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  evt_t                 ev,
  input  logic [DATA_BITS-1:0] rxByte,
  output ctrl_t                ctl
);

  localparam logic [LEN_BITS-1:0] ONE_LEFT = LEN_BITS'(1);

  pktState_e           state, nextState;
  logic [LEN_BITS-1:0] remain, nextRemain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_SYNC;
      remain <= '0;
    end else begin
      state  <= nextState;
      remain <= nextRemain;
    end
  end

  always_comb begin
    ctl        = '0;
    nextState  = state;
    nextRemain = remain;
    if (ev.byteDone) begin
      if (state inside {S_ID, S_CNT, S_DATA, S_SUM} && !ev.stopOk) begin
        ctl.frameBad = 1'b1;
        nextState    = S_DROP;
      end else begin
        unique case (state)
          S_ID: begin
            ctl.latchId = 1'b1;
            nextState   = S_CNT;
          end
          S_CNT: begin
            ctl.latchCnt = 1'b1;
            nextRemain   = rxByte[LEN_BITS-1:0];
            nextState    = (rxByte[LEN_BITS-1:0] == '0) ? S_SUM : S_DATA;
          end
          S_DATA: begin
            ctl.emitData = 1'b1;
            nextRemain   = remain - 1'b1;
            if (remain == ONE_LEFT) nextState = S_SUM;
          end
          S_SUM: begin
            ctl.accSum = 1'b1;
            nextState  = S_TAIL;
          end
          S_TAIL: begin
            ctl.frameBad = 1'b1;
            nextState    = S_DROP;
          end
          default: ;
        endcase
      end
    end else if (ev.idle) begin
      unique case (state)
        S_SYNC, S_DROP, S_ID: nextState = S_ID;
        S_TAIL: begin
          ctl.finish = 1'b1;
          nextState  = S_ID;
        end
        default: begin
          ctl.frameBad = 1'b1;
          nextState    = S_ID;
        end
      endcase
    end
  end

  AST_DATA_REMAIN: assert property (@(posedge clk) disable iff (!rstN)
    state == S_DATA |-> remain != '0); // R4
  AST_SYNC_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == S_SYNC && state != S_SYNC) |-> $past(ev.idle)); // R1

endmodule

// File: rtl/pkt_receiver.sv
module pkt_receiver
  import pkr_pkg::*;
#(
  parameter int OVERSAMPLE = 4,
  parameter int DATA_BITS  = 8,
  parameter int LEN_BITS   = 4,
  parameter int IDLE_BITS  = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleTick,
  input  logic                 rxLine,
  output logic [DATA_BITS-1:0] senderId,
  output logic [DATA_BITS-1:0] countOut,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 dataValid,
  output logic                 pktDone,
  output logic                 csumErr,
  output logic                 frameErr
);

  evt_t                 ev;
  ctrl_t                ctl;
  logic [DATA_BITS-1:0] rxByte;

  pkr_datapath #(
    .OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS), .IDLE_BITS(IDLE_BITS)
  ) uData (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .ctl(ctl), .ev(ev), .rxByte(rxByte),
    .senderId(senderId), .countOut(countOut), .dataOut(dataOut),
    .dataValid(dataValid), .pktDone(pktDone), .csumErr(csumErr),
    .frameErr(frameErr)
  );

  pkr_control #(
    .DATA_BITS(DATA_BITS), .LEN_BITS(LEN_BITS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte), .ctl(ctl)
  );

endmodule

// File: tb/tb_pkt_receiver.sv
module tb_pkt_receiver;

  typedef struct {
    int kind;   // 0 data, 1 done, 2 frame error
    int a;
    int b;
    int c;
  } expEv_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxLine = 1'b1;
  logic [7:0] senderId, countOut, dataOut;
  logic       dataValid, pktDone, csumErr, frameErr;

  int     nChecks = 0;
  int     nFails = 0;
  bit     finished = 1'b0;
  expEv_t expQ[$];
  logic [7:0] dat[16];

  always #5 clk = ~clk;

  pkt_receiver dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .senderId(senderId), .countOut(countOut), .dataOut(dataOut),
    .dataValid(dataValid), .pktDone(pktDone), .csumErr(csumErr),
    .frameErr(frameErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void pushEv(input int k, input int a, input int b, input int c);
    expEv_t e;
    e.kind = k; e.a = a; e.b = b; e.c = c;
    expQ.push_back(e);
  endfunction

  // Reference monitor: compares every clock against the expected event queue
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (dataValid || pktDone || frameErr) begin
        int k;
        expEv_t e;
        k = dataValid ? 0 : (pktDone ? 1 : 2);
        if (expQ.size() == 0) begin
          check(1'b0, "R1/R8 unexpected strobe", k, -1);
        end else begin
          e = expQ.pop_front();
          check(e.kind == k, "R5/R7/R8/R9/R10 event kind", k, e.kind);
          if (e.kind == k && k == 0)
            check(dataOut == 8'(e.a), "R5 data byte", dataOut, e.a);
          if (e.kind == k && k == 1) begin
            check(senderId == 8'(e.a), "R3 sender byte", senderId, e.a);
            check(countOut == 8'(e.b), "R4 count byte", countOut, e.b);
            check(csumErr == 1'(e.c), "R7 checksum flag", csumErr, e.c);
          end
        end
      end else if (csumErr) begin
        check(1'b0, "R7 csumErr without pktDone", 1, 0);
      end
    end
  end

  task automatic ticks(input logic lvl, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxLine = lvl; sampleTick = 1'b0;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk); sampleTick = 1'b1;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic stopLvl);
    ticks(1'b0, 4);
    for (int i = 0; i < 8; i++) ticks(b[i], 4);
    ticks(stopLvl, 4);
  endtask

  task automatic sendIdle();
    ticks(1'b1, 48);
  endtask

  task automatic settle(input string req);
    ticks(1'b1, 4);
    check(expQ.size() == 0, req, expQ.size(), 0);
  endtask

  task automatic goodPacket(input logic [7:0] id, input logic [7:0] cnt, input logic [7:0] corrupt);
    logic [7:0] sum;
    sum = id ^ cnt;
    sendByte(id, 1'b1);
    sendByte(cnt, 1'b1);
    for (int i = 0; i < int'(cnt[3:0]); i++) begin
      pushEv(0, dat[i], 0, 0);
      sendByte(dat[i], 1'b1);
      sum = sum ^ dat[i];
    end
    pushEv(1, id, cnt, (corrupt != 8'h00) ? 1 : 0);
    sendByte(sum ^ corrupt, 1'b1);
    sendIdle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset values
    check(senderId == 8'h00 && countOut == 8'h00 && dataOut == 8'h00, "R1 reset bytes",
          {senderId, countOut}, 0);
    check(!dataValid && !pktDone && !csumErr && !frameErr, "R1 reset strobes",
          {dataValid, pktDone, csumErr, frameErr}, 0);

    // R1: bytes before the first idle gap are ignored
    sendByte(8'h3C, 1'b1);
    sendByte(8'h01, 1'b1);
    sendByte(8'h3D, 1'b1);
    sendIdle();
    settle("R1 pre-idle bytes ignored");
    check(senderId == 8'h00, "R1 sender untouched", senderId, 0);

    // R3 R4 R5 R7: three data bytes, good sum
    dat[0] = 8'h11; dat[1] = 8'h22; dat[2] = 8'h33;
    goodPacket(8'h5A, 8'h03, 8'h00);
    settle("R5 packet with three bytes complete");

    // R4: zero count, upper nibble carried in countOut
    goodPacket(8'h81, 8'hA0, 8'h00);
    settle("R4 zero-count packet complete");
    check(countOut == 8'hA0, "R4 upper nibble on countOut", countOut, 8'hA0);

    // R6: fifteen all-ones data bytes do not look like idle
    for (int i = 0; i < 16; i++) dat[i] = 8'hFF;
    goodPacket(8'hFF, 8'h0F, 8'h00);
    settle("R6 all-ones payload complete");

    // R7: corrupted checksum
    goodPacket(8'h42, 8'h02, 8'h10);
    settle("R7 bad checksum reported");

    // R8: stop bit low on a data byte, following bytes ignored
    sendByte(8'h11, 1'b1);
    sendByte(8'h02, 1'b1);
    pushEv(2, 0, 0, 0);
    sendByte(8'h55, 1'b0);
    sendByte(8'h66, 1'b1);
    sendIdle();
    settle("R8 low stop bit");

    // R9: idle before the checksum
    sendByte(8'h22, 1'b1);
    sendByte(8'h03, 1'b1);
    pushEv(0, 8'h77, 0, 0);
    sendByte(8'h77, 1'b1);
    pushEv(2, 0, 0, 0);
    sendIdle();
    settle("R9 early idle");

    // R10: extra byte after the checksum
    sendByte(8'h33, 1'b1);
    sendByte(8'h00, 1'b1);
    sendByte(8'h33, 1'b1);
    pushEv(2, 0, 0, 0);
    sendByte(8'h99, 1'b1);
    sendIdle();
    settle("R10 trailing byte");

    // R2: one-strobe glitch is discarded; R11: recovery after errors
    ticks(1'b0, 1);
    ticks(1'b1, 8);
    dat[0] = 8'hC3;
    goodPacket(8'h07, 8'h01, 8'h00);
    settle("R2 R11 glitch ignored, packet after errors");
    check(senderId == 8'h07 && dataOut == 8'hC3, "R11 final outputs",
          {senderId, dataOut}, {8'h07, 8'hC3});

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule